// File: doc/BRIEF.md
# AHB-Lite to Peripheral Bus Bridge

This block sits as an AHB-Lite slave and serves a set of narrow, slow peripherals. It maps a window of 31 peripheral slots, each 4 KB in size. For every accepted transfer it raises one select line for the target slot and drives the offset inside the slot, the byte lanes, the write data and a write strobe on a simple single-cycle peripheral bus. Read data comes back on a shared read bus.

Each slot has a static data-width code on a configuration input. A transfer wider than its peripheral is split into a run of narrow accesses. They go in ascending address order, with the least significant part first. Read parts are gathered into one word, and HREADY is held low until the whole run is done. A read finishes in two clocks when no split is needed. A write always takes at least three clocks, because the write word is latched in one data-phase cycle before the peripheral sees it.

Transfers to the unused 32nd slot, misaligned transfers and sizes above a word are not passed to the peripheral bus. They get the two-cycle AHB ERROR response instead.

States: `ST_IDLE` (no transfer in flight, HREADY high), `ST_WR_LATCH` (first data-phase cycle of a write, the write word is captured), `ST_XFER` (one narrow access per cycle), `ST_ERR_FIRST` (ERROR with HREADY low) and `ST_ERR_LAST` (ERROR with HREADY high).

Transitions:
- An accepted good read goes to `ST_XFER`.
- An accepted good write goes to `ST_WR_LATCH`, then to `ST_XFER`.
- An accepted bad transfer goes to `ST_ERR_FIRST`, then to `ST_ERR_LAST`.
- `ST_XFER` stays in place until its last beat.
- On the last beat of `ST_XFER`, and in `ST_ERR_LAST`, the bridge either takes the next address phase or returns to `ST_IDLE`.

Top module: `ahb_periph_bridge`

## Requirements
- R1: Address bits [16:12] name the slot (0 to 30). During a peripheral access exactly the matching bit of `pb_sel` is high and `pb_addr` carries the beat's byte offset (address bits [11:0]). Outside access cycles `pb_sel` is all zero.
- R2: A read that needs N narrow accesses keeps HREADY low for N-1 data-phase cycles and completes on the Nth, so a read without split takes two clocks from address phase to data.
- R3: A write that needs N narrow accesses completes on data-phase cycle N+1, so the minimum is three clocks. The first data-phase cycle of a write has HREADY low and no peripheral select.
- R4: Width codes per slot, bits [2s+1:2s] of `slot_width_cfg`: 00 means 8-bit, 01 means 16-bit, 10 means 32-bit, and 11 behaves as 32-bit. The beat size is the smaller of the transfer size and the peripheral width. The beat count is the transfer size divided by the beat size: 1, 2 or 4.
- R5: Beats go in ascending address order, starting at the transfer address and stepping by the beat size. `pb_lanes` bit i is high exactly for the bytes of the beat whose address bits [1:0] equal i (little-endian lanes).
- R6: On a write beat `pb_wr` is high and `pb_wdata` equals the AHB write word of the data phase. On a read beat `pb_wr` is low.
- R7: On the completing cycle of a read, each byte lane of `hrdata` covered by the transfer holds the `pb_rdata` byte returned in the beat that addressed that lane.
- R8: Slot 31, an HSIZE above 2, a halfword at an odd address or a word not on a 4-byte boundary gets an ERROR response. One cycle has HRESP high and HREADY low, the next has both high, and no peripheral select is raised.
- R9: A cycle with HSEL low or HTRANS IDLE/BUSY (HTRANS[1]=0) starts nothing: HREADY stays high, HRESP low, `pb_sel` zero.
- R10: While reset is asserted HREADY is high, HRESP low and `pb_sel`, `pb_lanes` and `pb_wr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Bridge selected by the AHB decoder |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write when high |
| hsize | input | 3 | AHB transfer size (0 byte, 1 halfword, 2 word) |
| hwdata | input | 32 | AHB write data (data phase) |
| hrdata | output | 32 | AHB read data |
| hready | output | 1 | Transfer done / bus ready |
| hresp | output | 1 | ERROR response when high |
| slot_width_cfg | input | 62 | Static 2-bit width code per slot |
| pb_sel | output | 31 | One-hot peripheral slot select |
| pb_addr | output | 12 | Byte offset within the slot |
| pb_wdata | output | 32 | Peripheral write data |
| pb_lanes | output | 4 | Active byte lanes of the beat |
| pb_wr | output | 1 | Peripheral write strobe |
| pb_rdata | input | 32 | Read data from the selected peripheral |

## Verification
The bench aims at every pairing of transfer size with peripheral width, including code 11, and checks each beat's select, offset, lanes and write data, plus the cycle in which HREADY rises.
- A bridge with a wrong beat count would finish too early or too late and leave lanes unread.
- A bridge that stepped the address wrongly or placed lanes big-endian would hit the wrong bytes, and the masked read word would come back scrambled.
- Writes are checked for the extra latch cycle. A design that skipped it would complete writes in two clocks, and a design that drove the peripheral from the live write bus would send stale data.
- Error cases cover slot 31, odd halfwords, misaligned words and oversize HSIZE. They catch a one-cycle ERROR, a missing ERROR, or a stray select on a rejected access.

// File: rtl/ahbpb_pkg.sv
package ahbpb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LATCH,
        ST_XFER,
        ST_ERR_FIRST,
        ST_ERR_LAST
    } bridge_state_e;

    localparam logic [1:0] WCODE_8  = 2'b00;
    localparam logic [1:0] WCODE_16 = 2'b01;
    localparam logic [1:0] WCODE_32 = 2'b10;

    // log2 of the byte width a peripheral width code stands for
    function automatic logic [1:0] code_to_size(input logic [1:0] code);
        logic [1:0] sz;
        unique case (code)
            WCODE_8:  sz = 2'd0;
            WCODE_16: sz = 2'd1;
            default:  sz = 2'd2;
        endcase
        return sz;
    endfunction

endpackage

// File: rtl/ahbpb_decode.sv
module ahbpb_decode #(
    parameter int ADDR_W     = 32,
    parameter int SLOT_COUNT = 31,
    parameter int SLOT_AW    = 12,
    localparam int SLOT_IDX_W = $clog2(SLOT_COUNT + 1)
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2:0]              size,
    input  logic [2*SLOT_COUNT-1:0] slot_width_cfg,
    output logic [SLOT_IDX_W-1:0]   slot_idx,
    output logic                    addr_good,
    output logic [1:0]              width_code
);
    import ahbpb_pkg::*;

    logic slot_ok;
    logic align_ok;

    assign slot_idx = addr[SLOT_AW +: SLOT_IDX_W];
    assign slot_ok  = (int'(slot_idx) < SLOT_COUNT);

    always_comb begin
        unique case (size)
            3'd0:    align_ok = 1'b1;
            3'd1:    align_ok = (addr[0] == 1'b0);
            3'd2:    align_ok = (addr[1:0] == 2'b00);
            default: align_ok = 1'b0;
        endcase
    end

    assign addr_good = slot_ok && align_ok;

    always_comb begin
        width_code = WCODE_32;
        for (int i = 0; i < SLOT_COUNT; i++) begin
            if (slot_idx == SLOT_IDX_W'(i)) begin
                width_code = slot_width_cfg[2*i +: 2];
            end
        end
    end

endmodule

// File: rtl/ahbpb_beat_plan.sv
module ahbpb_beat_plan (
    input  logic [1:0] xfer_size,
    input  logic [1:0] width_code,
    output logic [1:0] beat_size,
    output logic [1:0] last_beat
);
    import ahbpb_pkg::*;

    logic [1:0] periph_size;
    logic [1:0] split_shift;

    assign periph_size = code_to_size(width_code);
    assign beat_size   = (xfer_size < periph_size) ? xfer_size : periph_size;
    assign split_shift = xfer_size - beat_size;

    always_comb begin
        unique case (split_shift)
            2'd0:    last_beat = 2'd0;
            2'd1:    last_beat = 2'd1;
            default: last_beat = 2'd3;
        endcase
    end

endmodule

// File: rtl/ahbpb_lane_unit.sv
module ahbpb_lane_unit #(
    parameter int LANES = 4,
    localparam int LO_W = $clog2(LANES)
) (
    input  logic [LO_W-1:0]  addr_lo,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lanes
);
    logic [LO_W+1:0] span_end;

    assign span_end = (LO_W+2)'(addr_lo) + ((LO_W+2)'(1) << size);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = ((LO_W+2)'(g) >= (LO_W+2)'(addr_lo)) &&
                          ((LO_W+2)'(g) <  span_end);
    end

endmodule

// File: rtl/ahb_periph_bridge.sv
module ahb_periph_bridge #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SLOT_COUNT = 31,
    parameter int SLOT_AW    = 12,
    localparam int LANES      = DATA_W / 8,
    localparam int SLOT_IDX_W = $clog2(SLOT_COUNT + 1),
    localparam int CFG_W      = 2 * SLOT_COUNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hsel,
    input  logic [ADDR_W-1:0]     haddr,
    input  logic [1:0]            htrans,
    input  logic                  hwrite,
    input  logic [2:0]            hsize,
    input  logic [DATA_W-1:0]     hwdata,
    output logic [DATA_W-1:0]     hrdata,
    output logic                  hready,
    output logic                  hresp,
    input  logic [CFG_W-1:0]      slot_width_cfg,
    output logic [SLOT_COUNT-1:0] pb_sel,
    output logic [SLOT_AW-1:0]    pb_addr,
    output logic [DATA_W-1:0]     pb_wdata,
    output logic [LANES-1:0]      pb_lanes,
    output logic                  pb_wr,
    input  logic [DATA_W-1:0]     pb_rdata
);
    import ahbpb_pkg::*;

    bridge_state_e state_q, state_d;

    logic [SLOT_IDX_W-1:0] dec_slot;
    logic                  dec_good;
    logic [1:0]            dec_width;
    logic [1:0]            plan_beat_size;
    logic [1:0]            plan_last_beat;

    logic [SLOT_IDX_W-1:0] slot_q;
    logic [SLOT_AW-1:0]    cur_addr_q;
    logic [1:0]            beat_size_q;
    logic [1:0]            beat_last_q;
    logic [1:0]            beat_cnt_q;
    logic                  write_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [DATA_W-1:0]     rd_acc_q;
    logic [LANES-1:0]      beat_lanes;

    logic accept;
    logic last_beat;

    ahbpb_decode #(
        .ADDR_W    (ADDR_W),
        .SLOT_COUNT(SLOT_COUNT),
        .SLOT_AW   (SLOT_AW)
    ) decode_i (
        .addr          (haddr),
        .size          (hsize),
        .slot_width_cfg(slot_width_cfg),
        .slot_idx      (dec_slot),
        .addr_good     (dec_good),
        .width_code    (dec_width)
    );

    ahbpb_beat_plan plan_i (
        .xfer_size (hsize[1:0]),
        .width_code(dec_width),
        .beat_size (plan_beat_size),
        .last_beat (plan_last_beat)
    );

    ahbpb_lane_unit #(
        .LANES(LANES)
    ) lane_i (
        .addr_lo(cur_addr_q[$clog2(LANES)-1:0]),
        .size   (beat_size_q),
        .lanes  (beat_lanes)
    );

    assign last_beat = (beat_cnt_q == beat_last_q);
    assign accept    = hready && hsel && htrans[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = ST_IDLE;
            ST_WR_LATCH:  state_d = ST_XFER;
            ST_XFER:      state_d = last_beat ? ST_IDLE : ST_XFER;
            ST_ERR_FIRST: state_d = ST_ERR_LAST;
            ST_ERR_LAST:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (accept) begin
            if (!dec_good) begin
                state_d = ST_ERR_FIRST;
            end else if (hwrite) begin
                state_d = ST_WR_LATCH;
            end else begin
                state_d = ST_XFER;
            end
        end
    end

    // outputs
    always_comb begin
        hready   = 1'b1;
        hresp    = 1'b0;
        pb_sel   = '0;
        pb_lanes = '0;
        pb_wr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                hready = 1'b1;
            end
            ST_WR_LATCH: begin
                hready = 1'b0;
            end
            ST_XFER: begin
                hready   = last_beat;
                pb_lanes = beat_lanes;
                pb_wr    = write_q;
                for (int i = 0; i < SLOT_COUNT; i++) begin
                    pb_sel[i] = (slot_q == SLOT_IDX_W'(i));
                end
            end
            ST_ERR_FIRST: begin
                hready = 1'b0;
                hresp  = 1'b1;
            end
            ST_ERR_LAST: begin
                hready = 1'b1;
                hresp  = 1'b1;
            end
            default: begin
                hready = 1'b1;
            end
        endcase
    end

    assign pb_addr  = cur_addr_q;
    assign pb_wdata = wdata_q;

    // read word: live lanes of the current beat over gathered earlier beats
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign hrdata[8*g +: 8] = beat_lanes[g] ? pb_rdata[8*g +: 8]
                                                : rd_acc_q[8*g +: 8];
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q      <= '0;
            cur_addr_q  <= '0;
            beat_size_q <= '0;
            beat_last_q <= '0;
            beat_cnt_q  <= '0;
            write_q     <= 1'b0;
            wdata_q     <= '0;
            rd_acc_q    <= '0;
        end else if (accept) begin
            slot_q      <= dec_slot;
            cur_addr_q  <= haddr[SLOT_AW-1:0];
            beat_size_q <= plan_beat_size;
            beat_last_q <= plan_last_beat;
            beat_cnt_q  <= '0;
            write_q     <= hwrite;
        end else if (state_q == ST_WR_LATCH) begin
            wdata_q <= hwdata;
        end else if (state_q == ST_XFER && !last_beat) begin
            beat_cnt_q <= beat_cnt_q + 2'd1;
            cur_addr_q <= cur_addr_q + (SLOT_AW'(1) << beat_size_q);
            if (!write_q) begin
                for (int i = 0; i < LANES; i++) begin
                    if (beat_lanes[i]) begin
                        rd_acc_q[8*i +: 8] <= pb_rdata[8*i +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ahb_periph_bridge_chk.sv
module ahb_periph_bridge_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SLOT_COUNT = 31,
    parameter int SLOT_AW    = 12,
    localparam int LANES = DATA_W / 8,
    localparam int CFG_W = 2 * SLOT_COUNT
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hsel,
    input logic [ADDR_W-1:0]     haddr,
    input logic [1:0]            htrans,
    input logic                  hwrite,
    input logic [2:0]            hsize,
    input logic [DATA_W-1:0]     hwdata,
    input logic [DATA_W-1:0]     hrdata,
    input logic                  hready,
    input logic                  hresp,
    input logic [CFG_W-1:0]      slot_width_cfg,
    input logic [SLOT_COUNT-1:0] pb_sel,
    input logic [SLOT_AW-1:0]    pb_addr,
    input logic [DATA_W-1:0]     pb_wdata,
    input logic [LANES-1:0]      pb_lanes,
    input logic                  pb_wr,
    input logic [DATA_W-1:0]     pb_rdata
);

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pb_sel));

    p_write_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel && htrans[1] && hwrite) |=> (!hready && pb_sel == '0));

    p_lane_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_sel != '0) |-> ($countones(pb_lanes) == 1 ||
                            $countones(pb_lanes) == 2 ||
                            $countones(pb_lanes) == 4));

    p_wr_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr |-> (pb_sel != '0));

    p_err_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready) |=> (hresp && hready));

    p_err_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hresp |-> (pb_sel == '0));

    p_idle_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !(hsel && htrans[1])) |=> (hready && !hresp && pb_sel == '0));

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (hready && !hresp && pb_sel == '0 && pb_lanes == '0 && !pb_wr));

endmodule

bind ahb_periph_bridge ahb_periph_bridge_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SLOT_COUNT(SLOT_COUNT),
    .SLOT_AW   (SLOT_AW)
) chk_i (.*);

// File: tb/ahb_periph_bridge_tb_top.sv
`timescale 1ns/1ps
module ahb_periph_bridge_tb_top;

    localparam int SLOTS = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready;
    logic        hresp;
    logic [61:0] slot_width_cfg = '0;
    logic [30:0] pb_sel;
    logic [11:0] pb_addr;
    logic [31:0] pb_wdata;
    logic [3:0]  pb_lanes;
    logic        pb_wr;
    logic [31:0] pb_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ahb_periph_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata),
        .hready(hready), .hresp(hresp), .slot_width_cfg(slot_width_cfg),
        .pb_sel(pb_sel), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_lanes(pb_lanes), .pb_wr(pb_wr), .pb_rdata(pb_rdata)
    );

    function automatic logic [7:0] periph_byte(input int slot, input logic [9:0] widx, input int lane);
        return 8'(slot * 29 + int'(widx) * 7 + lane * 61 + 90);
    endfunction

    function automatic logic [31:0] periph_word(input int slot, input logic [9:0] widx);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = periph_byte(slot, widx, i);
        return w;
    endfunction

    // peripheral read model
    always_comb begin
        pb_rdata = 32'hDEAD_BEEF;
        for (int s = 0; s < SLOTS; s++) begin
            if (pb_sel[s]) pb_rdata = periph_word(s, pb_addr[11:2]);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int size_of_code(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    task automatic run_xfer(input logic [31:0] a, input logic [2:0] sz, input bit wr, input logic [31:0] wd);
        int cycles;
        int nrec;
        bit first_ok;
        bit beats_ok;
        logic [31:0] beat_addr_log [8];
        logic [3:0]  beat_lane_log [8];
        logic [30:0] beat_sel_log [8];
        logic        beat_wr_log [8];
        logic [31:0] beat_wd_log [8];
        logic [31:0] rd;
        bit resp;
        int slot;
        bit err;
        int bsz;
        int n;
        int exp_cycles;
        logic [3:0] xmask;
        logic [31:0] bmask;
        logic [31:0] expw;

        @(negedge clk);
        hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = wr; hsize = sz;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        cycles = 0; nrec = 0; first_ok = 1'b1;
        forever begin
            cycles++;
            if (pb_sel != '0 && nrec < 8) begin
                beat_addr_log[nrec] = {20'd0, pb_addr};
                beat_lane_log[nrec] = pb_lanes;
                beat_sel_log[nrec]  = pb_sel;
                beat_wr_log[nrec]   = pb_wr;
                beat_wd_log[nrec]   = pb_wdata;
                nrec++;
            end
            if (cycles == 1) first_ok = hresp && !hready;
            if (hready || cycles > 20) break;
            @(negedge clk);
        end
        rd = hrdata;
        resp = hresp;
        hwdata = 32'h0BAD_0BAD;

        slot = int'(a[16:12]);
        err = (slot == 31) || (sz > 3'd2) || (sz == 3'd1 && a[0]) || (sz == 3'd2 && a[1:0] != 2'b00);
        if (err) begin
            chk(cycles == 2, "R8 error length", 32'(cycles), 32'd2);
            chk(first_ok && resp, "R8 error phases", {30'd0, first_ok, resp}, 32'd3);
            chk(nrec == 0, "R8 no select on error", 32'(nrec), 32'd0);
        end else begin
            bsz = (int'(sz) < size_of_code(slot_width_cfg[2*slot +: 2])) ? int'(sz)
                  : size_of_code(slot_width_cfg[2*slot +: 2]);
            n = 1 << (int'(sz) - bsz);
            exp_cycles = wr ? n + 1 : n;
            chk(cycles == exp_cycles, wr ? "R3 write latency" : "R2 read latency",
                32'(cycles), 32'(exp_cycles));
            chk(!resp, "R8 okay response", {31'd0, resp}, 32'd0);
            chk(nrec == n, "R4 beat count", 32'(nrec), 32'(n));
            beats_ok = (nrec == n);
            for (int k = 0; k < n && k < nrec; k++) begin
                logic [11:0] ea;
                ea = a[11:0] + 12'(k << bsz);
                chk(beat_sel_log[k] == (31'd1 << slot), "R1 slot select",
                    {1'b0, beat_sel_log[k]}, {1'b0, 31'd1 << slot});
                chk(beat_addr_log[k] == {20'd0, ea}, "R5 beat address order",
                    beat_addr_log[k], {20'd0, ea});
                chk(beat_lane_log[k] == 4'(((1 << (1 << bsz)) - 1) << ea[1:0]), "R5 beat lanes",
                    {28'd0, beat_lane_log[k]}, 32'(((1 << (1 << bsz)) - 1) << ea[1:0]));
                chk(beat_wr_log[k] == wr, "R6 write strobe", {31'd0, beat_wr_log[k]}, {31'd0, wr});
                if (wr) chk(beat_wd_log[k] == wd, "R6 write data", beat_wd_log[k], wd);
            end
            if (!wr && beats_ok) begin
                xmask = 4'(((1 << (1 << int'(sz))) - 1) << a[1:0]);
                for (int i = 0; i < 4; i++) bmask[8*i +: 8] = {8{xmask[i]}};
                expw = periph_word(slot, a[11:2]);
                chk((rd & bmask) == (expw & bmask), "R7 read assembly", rd & bmask, expw & bmask);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [2:0]  sz;
        int slot;
        void'($urandom(32'd20240611));
        for (int s = 0; s < SLOTS; s++) slot_width_cfg[2*s +: 2] = 2'($urandom_range(0, 3));
        slot_width_cfg[2*1 +: 2] = 2'b00;
        slot_width_cfg[2*2 +: 2] = 2'b01;
        slot_width_cfg[2*3 +: 2] = 2'b10;
        slot_width_cfg[2*4 +: 2] = 2'b11;
        slot_width_cfg[2*30 +: 2] = 2'b00;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(hready && !hresp && pb_sel == '0 && pb_lanes == '0 && !pb_wr, "R10 reset outputs",
            {27'd0, hready, hresp, |pb_sel, |pb_lanes, pb_wr}, 32'h10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: selected but IDLE transfer, and BUSY, and hsel low with NONSEQ
        hsel = 1'b1; haddr = 32'h0000_1004; htrans = 2'b00; hwrite = 1'b1; hsize = 3'd2;
        @(negedge clk);
        chk(hready && !hresp && pb_sel == '0, "R9 idle transfer ignored",
            {29'd0, hready, hresp, |pb_sel}, 32'h4);
        htrans = 2'b01;
        @(negedge clk);
        chk(hready && !hresp && pb_sel == '0, "R9 busy transfer ignored",
            {29'd0, hready, hresp, |pb_sel}, 32'h4);
        hsel = 1'b0; htrans = 2'b10;
        @(negedge clk);
        chk(hready && !hresp && pb_sel == '0, "R9 unselected ignored",
            {29'd0, hready, hresp, |pb_sel}, 32'h4);
        htrans = 2'b00;

        // directed splits (R4, R5, R7, R2, R3)
        run_xfer(32'h0000_1010, 3'd2, 1'b0, 32'h0);          // word from 8-bit: 4 beats
        run_xfer(32'h0000_1014, 3'd2, 1'b1, 32'hA1B2_C3D4);  // word write to 8-bit
        run_xfer(32'h0000_2008, 3'd2, 1'b0, 32'h0);          // word from 16-bit: 2 beats
        run_xfer(32'h0000_200C, 3'd2, 1'b1, 32'h1357_9BDF);
        run_xfer(32'h0000_1022, 3'd1, 1'b0, 32'h0);          // halfword from 8-bit upper
        run_xfer(32'h0000_1022, 3'd1, 1'b1, 32'h55AA_0000);
        run_xfer(32'h0000_3003, 3'd0, 1'b0, 32'h0);          // byte from 32-bit
        run_xfer(32'h0000_3004, 3'd2, 1'b0, 32'h0);          // word, no split
        run_xfer(32'h0000_3008, 3'd2, 1'b1, 32'hCAFE_F00D);  // minimum write
        run_xfer(32'h0000_4010, 3'd2, 1'b0, 32'h0);          // code 11 as 32-bit
        run_xfer(32'h0001_EFFC, 3'd2, 1'b0, 32'h0);          // slot 30 top word, 8-bit
        // R8 error cases
        run_xfer(32'h0001_F000, 3'd0, 1'b0, 32'h0);          // slot 31
        run_xfer(32'h0000_1001, 3'd1, 1'b0, 32'h0);          // odd halfword
        run_xfer(32'h0000_1002, 3'd2, 1'b1, 32'h0);          // misaligned word
        run_xfer(32'h0000_1000, 3'd3, 1'b0, 32'h0);          // oversize

        // constrained random
        for (int t = 0; t < 400; t++) begin
            slot = ($urandom_range(0, 15) == 0) ? 31 : int'($urandom_range(0, 30));
            sz = ($urandom_range(0, 19) == 0) ? 3'd3 : 3'($urandom_range(0, 2));
            a = $urandom;
            a[16:12] = 5'(slot);
            if (sz == 3'd1) a[0] = 1'b0;
            if (sz >= 3'd2) a[1:0] = 2'b00;
            if ($urandom_range(0, 11) == 0) a[0] = 1'b1;
            run_xfer(a, sz, 1'($urandom_range(0, 1)), $urandom);
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule